// File: doc/BRIEF.md
# Scalar FP64 Minimum Select Unit

This unit picks the smaller of two double-precision values held in the low 64-bit lanes of two 128-bit vector operands. It writes the result into the low lane of a 128-bit output. The upper lane of the output is a straight copy of the first operand's upper lane. Zeros and NaNs are resolved by operand position, not by the usual symmetric minimum rules. A pair of zeros, or any NaN among the inputs, always yields the second operand bit-for-bit. A signalling NaN therefore leaves the unit unquieted.

A one-bit lane mask can suppress the low-lane write. When it does, the low lane either keeps a caller-supplied previous destination value (merging) or is cleared (zeroing). The unit also raises an invalid-operation flag and a denormal-operand flag for the active lane.

Operands are sampled when `in_valid` is high. Result and flags are registered and appear one clock later with `out_valid`.

Top module: `scalar_fpmin_unit`

## Requirements
- R1: When both low-lane inputs are zero (exponent and fraction all zero, either sign), the low result equals the second operand, so +0 and -0 are not ordered.
- R2: When either low-lane input is a NaN (exponent all ones, fraction nonzero; signalling when fraction bit 51 is 0), the low result is the second operand unchanged, including a signalling NaN with its quiet bit still clear.
- R3: For two non-NaN inputs that are not both zero, the first operand is chosen only when it is strictly less under sign-magnitude ordering (negatives reverse by magnitude, subnormals compared as raw bits); otherwise the second operand is chosen.
- R4: Result bits 127:64 equal the first operand's bits 127:64 of the sampled transaction, whatever the mask.
- R5: With `mask_en`=1, `mask_bit`=0 and `zero_mode`=0, the low result equals `prev_low`.
- R6: With `mask_en`=1, `mask_bit`=0 and `zero_mode`=1, the low result is zero.
- R7: With `mask_en`=0, or with `mask_bit`=1, the low result is the computed minimum.
- R8: `flag_invalid` is 1 for an active lane when either input is any NaN, quiet or signalling. It is 0 when the lane is masked off.
- R9: `flag_denormal` is 1 for an active lane when either input is subnormal (exponent zero, fraction nonzero). It is 0 when the lane is masked off.
- R10: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. Result and flags hold their values while `in_valid` is low.
- R11: Synchronous reset clears `out_valid`, `result` and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src_a | input | 128 | First operand; its upper lane passes through |
| src_b | input | 128 | Second operand; only its low lane is used |
| mask_en | input | 1 | Enables lane masking |
| mask_bit | input | 1 | Lane mask bit; 1 lets the low lane be written |
| zero_mode | input | 1 | 1 clears a masked lane; 0 keeps `prev_low` |
| prev_low | input | 64 | Previous destination low lane, used for merging |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 128 | Upper lane from `src_a`, low lane minimum or masked value |
| flag_invalid | output | 1 | An input of the active lane was a NaN |
| flag_denormal | output | 1 | An input of the active lane was subnormal |

## Verification
Directed pairs cover the cases that separate an operand-order rule from a symmetric one:
- +0/-0 in both orders.
- A NaN in each position, and a signalling NaN in the second position.
- Two negatives in both orders.
- Subnormals against each other.

Each of these gives a different answer when the sign-magnitude compare or the tie and NaN rules are wrong. Random operands drawn from mixed classes (zeros, NaNs, subnormals, near-equal normals, raw bit patterns) are checked against a model built on the simulator's real-number compare. The mask inputs are randomized as well, so merging, zeroing and flag suppression are all exercised against the same operands.

// File: rtl/fpmin_pkg.sv
package fpmin_pkg;
  localparam int unsigned DP_EXP_W  = 11;
  localparam int unsigned DP_FRAC_W = 52;

  typedef struct packed {
    logic nan;
    logic snan;
    logic zero;
    logic sub;
  } fp_class_t;
endpackage

// File: rtl/fp_classify.sv
module fp_classify
  import fpmin_pkg::*;
#(
  parameter int unsigned EXP_W  = DP_EXP_W,
  parameter int unsigned FRAC_W = DP_FRAC_W,
  localparam int unsigned W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] val,
  output fp_class_t    cls
);
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_max, exp_min, frac_nz;

  always_comb begin
    expo     = val[W-2:FRAC_W];
    frac     = val[FRAC_W-1:0];
    exp_max  = &expo;
    exp_min  = ~|expo;
    frac_nz  = |frac;
    cls.nan  = exp_max & frac_nz;
    cls.snan = exp_max & frac_nz & ~frac[FRAC_W-1];
    cls.zero = exp_min & ~frac_nz;
    cls.sub  = exp_min & frac_nz;
  end
endmodule

// File: rtl/fp_lt_compare.sv
module fp_lt_compare #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_lt_b
);
  logic [W-2:0] mag_a, mag_b;

  always_comb begin
    mag_a = a[W-2:0];
    mag_b = b[W-2:0];
    unique case ({a[W-1], b[W-1]})
      2'b00:   a_lt_b = (mag_a < mag_b);
      2'b11:   a_lt_b = (mag_a > mag_b);
      2'b10:   a_lt_b = 1'b1;
      default: a_lt_b = 1'b0;
    endcase
  end
endmodule

// File: rtl/fp_min_pick.sv
module fp_min_pick
  import fpmin_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  fp_class_t    cls_a,
  input  fp_class_t    cls_b,
  input  logic         a_lt_b,
  output logic [W-1:0] min_val,
  output logic         any_nan,
  output logic         any_sub
);
  logic take_b;

  always_comb begin
    any_nan = cls_a.nan | cls_b.nan;
    any_sub = cls_a.sub | cls_b.sub;
    take_b  = any_nan | (cls_a.zero & cls_b.zero) | ~a_lt_b;
    min_val = take_b ? b : a;
  end
endmodule

// File: rtl/scalar_fpmin_unit.sv
module scalar_fpmin_unit
  import fpmin_pkg::*;
#(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned LANE_W = 64,
  parameter int unsigned EXP_W  = DP_EXP_W,
  localparam int unsigned FRAC_W = LANE_W - 1 - EXP_W,
  localparam int unsigned N_OPS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic              mask_en,
  input  logic              mask_bit,
  input  logic              zero_mode,
  input  logic [LANE_W-1:0] prev_low,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result,
  output logic              flag_invalid,
  output logic              flag_denormal
);
  logic [LANE_W-1:0] lane [N_OPS];
  fp_class_t         cls  [N_OPS];
  logic              a_lt_b, any_nan, any_sub, lane_active;
  logic [LANE_W-1:0] min_val, low_next;

  assign lane[0] = src_a[LANE_W-1:0];
  assign lane[1] = src_b[LANE_W-1:0];

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val(lane[i]),
      .cls(cls[i])
    );
  end

  fp_lt_compare #(.W(LANE_W)) u_cmp (
    .a(lane[0]), .b(lane[1]), .a_lt_b(a_lt_b)
  );

  fp_min_pick #(.W(LANE_W)) u_pick (
    .a(lane[0]), .b(lane[1]), .cls_a(cls[0]), .cls_b(cls[1]),
    .a_lt_b(a_lt_b), .min_val(min_val), .any_nan(any_nan), .any_sub(any_sub)
  );

  always_comb begin
    lane_active = ~mask_en | mask_bit;
    if (lane_active)    low_next = min_val;
    else if (zero_mode) low_next = '0;
    else                low_next = prev_low;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid     <= 1'b0;
      result        <= '0;
      flag_invalid  <= 1'b0;
      flag_denormal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result[VEC_W-1:LANE_W] <= src_a[VEC_W-1:LANE_W];
        result[LANE_W-1:0]     <= low_next;
        flag_invalid           <= lane_active & any_nan;
        flag_denormal          <= lane_active & any_sub;
      end
    end
  end

  // Assertions, each tagged with the requirement it guards
  assert_upper_pass_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> result[VEC_W-1:LANE_W] == $past(src_a[VEC_W-1:LANE_W]));

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result)));

  assert_merge_keep_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !mask_bit && !zero_mode) |=>
      result[LANE_W-1:0] == $past(prev_low));

  assert_zeroing_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !mask_bit && zero_mode) |=>
      (result[LANE_W-1:0] == '0 && !flag_invalid && !flag_denormal));

  assert_pick_operand_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!mask_en || mask_bit)) |=>
      (result[LANE_W-1:0] == $past(src_a[LANE_W-1:0]) ||
       result[LANE_W-1:0] == $past(src_b[LANE_W-1:0])));

  assert_nan_second_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!mask_en || mask_bit) && (cls[0].nan || cls[1].nan)) |=>
      (result[LANE_W-1:0] == $past(src_b[LANE_W-1:0]) && flag_invalid));
endmodule

// File: tb/sim_scalar_fpmin_unit.sv
module sim_scalar_fpmin_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [127:0] src_a, src_b;
  logic         mask_en, mask_bit, zero_mode;
  logic [63:0]  prev_low;
  logic         out_valid;
  logic [127:0] result;
  logic         flag_invalid, flag_denormal;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #10 clk = ~clk;

  scalar_fpmin_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .mask_en(mask_en), .mask_bit(mask_bit), .zero_mode(zero_mode),
    .prev_low(prev_low), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_denormal(flag_denormal)
  );

  localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] N_TWO  = 64'hC000_0000_0000_0000;
  localparam logic [63:0] P_ZERO = 64'h0;
  localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QNAN   = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN   = 64'h7FF0_0000_0000_0001;

  function automatic bit is_nan(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction
  function automatic bit is_sub(logic [63:0] x);
    return (x[62:52] == 11'h0) && (x[51:0] != 0);
  endfunction
  function automatic logic [63:0] ref_min(logic [63:0] a, logic [63:0] b);
    if (is_nan(a) || is_nan(b)) return b;
    if ($bitstoreal(a) < $bitstoreal(b)) return a;
    return b;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(logic [127:0] a, logic [127:0] b, bit men, bit mb,
                        bit zm, logic [63:0] prev);
    logic [63:0] exp_low;
    bit          active;
    string       tag;
    @(negedge clk);
    in_valid = 1'b1; src_a = a; src_b = b;
    mask_en = men; mask_bit = mb; zero_mode = zm; prev_low = prev;
    @(negedge clk);
    in_valid = 1'b0;
    active = !men || mb;
    if (!active) begin
      exp_low = zm ? 64'h0 : prev;
      tag     = zm ? "R6" : "R5";
    end else begin
      exp_low = ref_min(a[63:0], b[63:0]);
      if (is_nan(a[63:0]) || is_nan(b[63:0]))               tag = "R2";
      else if (a[62:0] == 0 && b[62:0] == 0)               tag = "R1";
      else if (men)                                         tag = "R7";
      else                                                  tag = "R3";
    end
    chk("R10 out_valid", {127'd0, out_valid}, 128'd1);
    chk(tag, {64'd0, result[63:0]}, {64'd0, exp_low});
    chk("R4 upper", {64'd0, result[127:64]}, {64'd0, a[127:64]});
    chk("R8 invalid", {127'd0, flag_invalid},
        {127'd0, active && (is_nan(a[63:0]) || is_nan(b[63:0]))});
    chk("R9 denormal", {127'd0, flag_denormal},
        {127'd0, active && (is_sub(a[63:0]) || is_sub(b[63:0]))});
  endtask

  function automatic logic [63:0] pick_val();
    logic [63:0] v;
    v = {$urandom, $urandom};
    case ($urandom % 6)
      0: v = {v[63], 63'd0};
      1: v = {v[63], 11'h7FF, (v[51:0] == 0) ? 52'd1 : v[51:0]};
      2: v = {v[63], 11'h0, v[51:0]};
      3: v = {v[63], 11'h3FF, 48'd0, v[3:0]};
      4: v = {v[63], 11'h3FE + 11'(v[0]), 52'd0};
      default: ;
    endcase
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; src_a = '0; src_b = '0;
    mask_en = 1'b0; mask_bit = 1'b0; zero_mode = 1'b0; prev_low = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 out_valid", {127'd0, out_valid}, 128'd0);
    chk("R11 result", result, 128'd0);
    chk("R11 flags", {126'd0, flag_invalid, flag_denormal}, 128'd0);
    rst = 1'b0;

    // R1: zero pair returns second operand regardless of sign
    run_op({64'hAAAA, P_ZERO}, {64'h1, N_ZERO}, 0, 0, 0, 0);
    run_op({64'hBBBB, N_ZERO}, {64'h2, P_ZERO}, 0, 0, 0, 0);
    // R2 / R8: NaN in either position
    run_op({64'h1, P_ONE}, {64'h0, QNAN}, 0, 0, 0, 0);
    run_op({64'h2, QNAN}, {64'h0, P_TWO}, 0, 0, 0, 0);
    run_op({64'h3, N_ONE}, {64'h0, SNAN}, 0, 0, 0, 0);
    // R3: sign-magnitude ordering, negatives and subnormals
    run_op({64'h4, N_TWO}, {64'h0, N_ONE}, 0, 0, 0, 0);
    run_op({64'h5, N_ONE}, {64'h0, N_TWO}, 0, 0, 0, 0);
    run_op({64'h6, N_ONE}, {64'h0, P_ZERO}, 0, 0, 0, 0);
    run_op({64'h7, 64'h1}, {64'h0, 64'h2}, 0, 0, 0, 0);
    run_op({64'h8, 64'h8000_0000_0000_0003}, {64'h0, 64'h8000_0000_0000_0002}, 0, 0, 0, 0);
    // R5 / R6 / R7: masking, with a NaN to check flag suppression
    run_op({64'h9, P_ONE}, {64'h0, QNAN}, 1, 0, 0, 64'h1234_5678_9ABC_DEF0);
    run_op({64'hA, 64'h1}, {64'h0, P_TWO}, 1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    run_op({64'hB, N_ONE}, {64'h0, P_ONE}, 1, 1, 1, 64'hFFFF_FFFF_FFFF_FFFF);

    // R10: no valid input -> out_valid low and outputs held
    held = result;
    @(negedge clk);
    chk("R10 idle valid", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    chk("R10 hold", result, held);

    for (int i = 0; i < 2000; i++) begin
      logic [127:0] ra, rb;
      bit men;
      ra  = {$urandom, $urandom, pick_val()};
      rb  = {$urandom, $urandom, pick_val()};
      men = ($urandom % 4) == 0;
      run_op(ra, rb, men, $urandom % 2 == 1, $urandom % 2 == 1,
             {$urandom, $urandom});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule